// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block connects a bus master that issues byte, halfword and word accesses to a register file whose registers each have a fixed native width. A width table, with one entry for every 4-byte slot of the register window, says how wide the registers in that slot are. For each master access the adapter issues one or more native-width accesses. A write narrower than the register becomes a read-modify-write. An access wider than the registers becomes a series of smaller accesses, most significant part first.

Both sides use a request/response handshake, and only one master access is in progress at a time. Data is big-endian: the byte at the lowest address is the most significant. Data on both sides is right-justified in the 32-bit data buses. Slots marked reserved, and offsets beyond the register window, complete at once without any downstream access.

Top module: `mwa_adapter`

## Requirements
- R1: Only the low 10 bits of `m_addr` are used as the offset. Offsets from 0x200 up are invalid. Such a read completes with data 0, and such a write completes with no effect. Neither makes any peripheral access.
- R2: Each 4-byte slot (offset bits 8:2) has a 2-bit width code: 0 reserved, 1 byte, 2 halfword, 3 word. The default map takes the slot number modulo 16 and gives it code 1 for 0-3, code 2 for 4-7, code 3 for 8-11 and code 0 for 12-15. Every peripheral access carries the native size of its slot.
- R3: An access to a reserved slot completes with read data 0 and makes no peripheral access.
- R4: When the access size equals the native width, exactly one peripheral access is made, with the same offset and data.
- R5: A read narrower than the register makes one native read at the register's aligned offset. It returns the addressed bytes, taking the lowest address as most significant.
- R6: A write narrower than the register makes a native read at the aligned offset, then a native write at the same offset. The write carries the value read, with only the addressed bytes replaced.
- R7: An access wider than the register becomes size/width native accesses at ascending offsets. Read data is assembled with the first access in the most significant position. Write data is sent most significant part first.
- R8: `p_req` stays high, with address, direction and data held, until `p_ack`. `m_gnt` is high only when no access is in progress. `m_rsp` is a one-cycle pulse that comes after the last peripheral transfer.
- R9: Size codes on `m_size` and `p_size` are 0 byte, 1 halfword, 2 word. `m_rdata` is zero for writes.
- R10: During and after reset, `m_gnt` is 1 and `p_req` and `m_rsp` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master request |
| m_gnt | output | 1 | Adapter idle; a request is taken this cycle |
| m_we | input | 1 | Master write (1) or read (0) |
| m_size | input | 2 | Master access size code |
| m_addr | input | 16 | Master byte offset |
| m_wdata | input | 32 | Master write data, right-justified |
| m_rsp | output | 1 | Completion pulse |
| m_rdata | output | 32 | Read data, valid with `m_rsp` |
| p_req | output | 1 | Peripheral request |
| p_ack | input | 1 | Peripheral completes the current access |
| p_we | output | 1 | Peripheral write (1) or read (0) |
| p_size | output | 2 | Native access size code |
| p_addr | output | 10 | Peripheral byte offset |
| p_wdata | output | 32 | Native write data, right-justified |
| p_rdata | input | 32 | Native read data, sampled with `p_ack` |

## Verification
The assertions assume that master accesses are naturally aligned (halfwords at even offsets, words at multiples of four) and that `m_size` never takes code 3. They also assume that the peripheral returns read data in the same cycle as its acknowledge. The stimulus uses only aligned addresses and the three legal size codes. It answers each peripheral request with the data of a big-endian byte array, after a delay of zero to two cycles. It checks every peripheral access against the slot's table width.

// File: rtl/mwa_pkg.sv
package mwa_pkg;

  localparam int DW    = 32;
  localparam int SLOTS = 128;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RESP = 2'd2
  } adp_state_e;

  // width code per slot: 0 reserved, 1 byte, 2 halfword, 3 word
  function automatic logic [2*SLOTS-1:0] default_map();
    logic [2*SLOTS-1:0] m;
    m = '0;
    for (int s = 0; s < SLOTS; s++) begin
      m[2*s +: 2] = 2'(((s % 16) / 4 + 1) % 4);
    end
    return m;
  endfunction

  function automatic logic [DW-1:0] lane_mask(logic [1:0] lg);
    case (lg)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/mwa_slot_lookup.sv
module mwa_slot_lookup #(
  parameter int OFFS_W = 10,
  parameter int SLOTS  = mwa_pkg::SLOTS,
  parameter logic [2*SLOTS-1:0] WMAP = mwa_pkg::default_map()
) (
  input  logic [OFFS_W-1:0] offs,
  output logic              invalid,
  output logic              reserved,
  output logic [1:0]        wlog
);
  localparam int LIMIT  = SLOTS * 4;
  localparam int SIDX_W = $clog2(SLOTS);

  logic [SIDX_W-1:0] slot;
  logic [1:0]        code;

  assign slot     = offs[SIDX_W+1:2];
  assign code     = WMAP[{slot, 1'b0} +: 2];
  assign invalid  = ({1'b0, offs} >= (OFFS_W+1)'(LIMIT));
  assign reserved = (code == 2'd0);
  assign wlog     = reserved ? 2'd0 : (code - 2'd1);

endmodule

// File: rtl/mwa_step_gen.sv
module mwa_step_gen #(
  parameter int OFFS_W = 10
) (
  input  logic [OFFS_W-1:0] a_q,
  input  logic [1:0]        sz,
  input  logic [1:0]        wlog,
  input  logic              we,
  input  logic [31:0]       wd,
  input  logic [1:0]        step,
  input  logic [2:0]        nstep,
  input  logic [31:0]       acc,
  input  logic [31:0]       prd,
  output logic [OFFS_W-1:0] p_addr,
  output logic              p_we,
  output logic [31:0]       p_wdata,
  output logic [31:0]       acc_nxt,
  output logic [31:0]       rsp_data
);
  import mwa_pkg::*;

  logic        wide, narrow;
  logic [31:0] wmask, smask;
  logic [2:0]  wbytes, sbytes, nsh3, chunk3;
  logic [1:0]  wm1, off, nsh, chunk;
  logic [4:0]  sh, csh;
  logic [5:0]  wbits;
  logic [OFFS_W-1:0] al_addr;

  assign wide   = (sz > wlog);
  assign narrow = (sz < wlog);
  assign wmask  = lane_mask(wlog);
  assign smask  = lane_mask(sz);
  assign wbytes = 3'd1 << wlog;
  assign sbytes = 3'd1 << sz;
  assign wm1    = 2'(wbytes - 3'd1);
  assign off    = a_q[1:0] & wm1;
  assign nsh3   = wbytes - sbytes - {1'b0, off};
  assign nsh    = nsh3[1:0];
  assign sh     = {nsh, 3'b000};
  assign chunk3 = nstep - 3'd1 - {1'b0, step};
  assign chunk  = chunk3[1:0];
  assign csh    = {chunk, 3'b000} << wlog;
  assign wbits  = 6'd8 << wlog;
  assign al_addr = a_q & ~{{(OFFS_W-2){1'b0}}, wm1};

  always_comb begin
    if (wide) begin
      p_addr  = a_q + (OFFS_W'(step) << wlog);
      p_we    = we;
      p_wdata = (wd >> csh) & wmask;
      acc_nxt = (acc << wbits) | (prd & wmask);
    end else if (narrow) begin
      p_addr  = al_addr;
      p_we    = we && (step == 2'd1);
      p_wdata = (acc & ~(smask << sh)) | ((wd & smask) << sh);
      acc_nxt = prd & wmask;
    end else begin
      p_addr  = a_q;
      p_we    = we;
      p_wdata = wd & wmask;
      acc_nxt = prd & wmask;
    end
    if (we)          rsp_data = '0;
    else if (narrow) rsp_data = (acc >> sh) & smask;
    else             rsp_data = acc & smask;
  end

endmodule

// File: rtl/mwa_adapter.sv
module mwa_adapter #(
  parameter int MADDR_W = 16,
  parameter int OFFS_W  = 10,
  parameter int SLOTS   = mwa_pkg::SLOTS,
  parameter logic [2*SLOTS-1:0] WMAP = mwa_pkg::default_map()
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               m_req,
  output logic               m_gnt,
  input  logic               m_we,
  input  logic [1:0]         m_size,
  input  logic [MADDR_W-1:0] m_addr,
  input  logic [31:0]        m_wdata,
  output logic               m_rsp,
  output logic [31:0]        m_rdata,
  output logic               p_req,
  input  logic               p_ack,
  output logic               p_we,
  output logic [1:0]         p_size,
  output logic [OFFS_W-1:0]  p_addr,
  output logic [31:0]        p_wdata,
  input  logic [31:0]        p_rdata
);
  import mwa_pkg::*;

  localparam int LIMIT = SLOTS * 4;

  adp_state_e st_q, st_d;
  logic [OFFS_W-1:0] a_q, offs_in;
  logic [1:0]  sz_q, wlog_q, wlog_in, step_q;
  logic        we_q, inv_in, rsv_in, skip_in;
  logic [31:0] wd_q, acc_q, acc_nxt, rsp_data;
  logic [2:0]  nstep_q, nstep_in;
  logic        accept, ack_en, last;

  assign offs_in = m_addr[OFFS_W-1:0];

  mwa_slot_lookup #(.OFFS_W(OFFS_W), .SLOTS(SLOTS), .WMAP(WMAP)) u_lookup (
    .offs(offs_in), .invalid(inv_in), .reserved(rsv_in), .wlog(wlog_in)
  );

  mwa_step_gen #(.OFFS_W(OFFS_W)) u_step (
    .a_q(a_q), .sz(sz_q), .wlog(wlog_q), .we(we_q), .wd(wd_q),
    .step(step_q), .nstep(nstep_q), .acc(acc_q), .prd(p_rdata),
    .p_addr(p_addr), .p_we(p_we), .p_wdata(p_wdata),
    .acc_nxt(acc_nxt), .rsp_data(rsp_data)
  );

  assign skip_in = inv_in | rsv_in;
  assign accept  = (st_q == ST_IDLE) && m_req;
  assign ack_en  = (st_q == ST_XFER) && p_ack;
  assign last    = (({1'b0, step_q} + 3'd1) == nstep_q);

  always_comb begin
    if (m_size > wlog_in)               nstep_in = 3'd1 << (m_size - wlog_in);
    else if (m_size < wlog_in && m_we)  nstep_in = 3'd2;
    else                                nstep_in = 3'd1;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (m_req) st_d = skip_in ? ST_RESP : ST_XFER;
      ST_XFER: if (p_ack && last) st_d = ST_RESP;
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      sz_q    <= '0;
      we_q    <= 1'b0;
      wd_q    <= '0;
      wlog_q  <= '0;
      nstep_q <= 3'd1;
    end else if (accept) begin
      a_q     <= offs_in;
      sz_q    <= m_size;
      we_q    <= m_we;
      wd_q    <= m_wdata;
      wlog_q  <= skip_in ? 2'd0 : wlog_in;
      nstep_q <= nstep_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      acc_q  <= '0;
    end else if (accept) begin
      step_q <= '0;
      acc_q  <= '0;
    end else if (ack_en) begin
      step_q <= step_q + 2'd1;
      acc_q  <= acc_nxt;
    end
  end

  assign m_gnt   = (st_q == ST_IDLE);
  assign m_rsp   = (st_q == ST_RESP);
  assign m_rdata = m_rsp ? rsp_data : '0;
  assign p_req   = (st_q == ST_XFER);
  assign p_size  = wlog_q;

  // R8: request held with its payload until acknowledged
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (p_req && !p_ack) |=> (p_req && $stable(p_addr) && $stable(p_we) && $stable(p_wdata)));

  // R8: completion is a single-cycle pulse
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    m_rsp |=> !m_rsp);

  // R8: no grant or completion while a downstream access is open
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    p_req |-> (!m_gnt && !m_rsp));

  // R1: out-of-window offset completes without downstream access
  a_r1_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_gnt && ({1'b0, m_addr[OFFS_W-1:0]} >= (OFFS_W+1)'(LIMIT))) |=> (!p_req && m_rsp));

  // R3: reserved slot completes without downstream access
  a_r3_reserved_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rsv_in) |=> (!p_req && m_rsp));

  // R6: the read half of a read-modify-write is followed by a write to the same offset
  a_r6_rmw_write: assert property (@(posedge clk) disable iff (!rst_n)
    (p_req && p_ack && !p_we && we_q && (sz_q < wlog_q)) |=> (p_req && p_we && $stable(p_addr)));

  // R7: split pieces walk upward by one native width
  a_r7_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (p_req && p_ack && !last && (sz_q > wlog_q)) |=>
      (p_req && p_addr == $past(p_addr) + (OFFS_W'(1) << p_size)));

endmodule

// File: tb/mwa_adapter_test.sv
module mwa_adapter_test;

  typedef struct {
    logic [31:0] rd;
    int          ops;
    string       tag;
  } exp_t;

  logic        clk, rst_n;
  logic        m_req, m_gnt, m_we, m_rsp;
  logic [1:0]  m_size;
  logic [15:0] m_addr;
  logic [31:0] m_wdata, m_rdata;
  logic        p_req, p_ack, p_we;
  logic [1:0]  p_size;
  logic [9:0]  p_addr;
  logic [31:0] p_wdata, p_rdata;

  int checks, errors;
  exp_t exp_q[$];
  logic [7:0] pmem [512];
  logic [7:0] gold [512];
  int ops_seen, ops_total, wait_c;
  logic prev_rsp, lat_we;
  logic [9:0] lat_addr;
  logic [1:0] lat_size;
  logic [31:0] lat_wdata;
  bit done;

  mwa_adapter uut (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_gnt(m_gnt), .m_we(m_we),
    .m_size(m_size), .m_addr(m_addr), .m_wdata(m_wdata), .m_rsp(m_rsp),
    .m_rdata(m_rdata), .p_req(p_req), .p_ack(p_ack), .p_we(p_we),
    .p_size(p_size), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int tbl_code(int slot);
    return ((slot % 16) / 4 + 1) % 4;
  endfunction

  function automatic void check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endfunction

  task automatic issue(bit we, int sz, int addr, logic [31:0] wd, string tag);
    int off = addr & 'h3FF;
    int nb = 1 << sz;
    int code;
    int wl;
    exp_t e;
    code = (off < 'h200) ? tbl_code(off >> 2) : 0;
    e.tag = tag;
    e.rd  = '0;
    if (code == 0) begin
      e.ops = 0;
    end else begin
      wl = code - 1;
      if (sz > wl)            e.ops = 1 << (sz - wl);
      else if (sz < wl && we) e.ops = 2;
      else                    e.ops = 1;
      for (int i = 0; i < nb; i++) begin
        if (we) gold[off + i] = wd[8*(nb-1-i) +: 8];
        else    e.rd = (e.rd << 8) | 32'(gold[off + i]);
      end
    end
    exp_q.push_back(e);
    @(negedge clk);
    while (!m_gnt) @(negedge clk);
    m_req = 1'b1; m_we = we; m_size = 2'(sz); m_addr = 16'(addr); m_wdata = wd;
    @(negedge clk);
    m_req = 1'b0;
  endtask

  // peripheral model and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ack) begin
        if (lat_we)
          for (int i = 0; i < (1 << lat_size); i++)
            pmem[lat_addr + 10'(i)] = lat_wdata[8*((1 << lat_size)-1-i) +: 8];
        ops_seen++;
        ops_total++;
        p_ack = 1'b0;
        wait_c = ops_total % 3;
      end else if (p_req) begin
        if (wait_c == 0) begin
          // R2: native size equals slot width code minus one
          check(p_size == 2'(tbl_code(int'(p_addr) >> 2) - 1) && p_addr < 10'h200,
                "R2", 32'(p_size), 32'(tbl_code(int'(p_addr) >> 2) - 1));
          p_rdata = '0;
          for (int i = 0; i < (1 << p_size); i++)
            p_rdata = (p_rdata << 8) | 32'(pmem[p_addr + 10'(i)]);
          lat_we = p_we; lat_addr = p_addr; lat_size = p_size; lat_wdata = p_wdata;
          p_ack = 1'b1;
        end else begin
          wait_c--;
        end
      end
      if (m_rsp) begin
        exp_t e;
        check(!prev_rsp, "R8", 32'(prev_rsp), 32'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", m_rdata, 32'd0);
        end else begin
          e = exp_q.pop_front();
          check(m_rdata == e.rd, e.tag, m_rdata, e.rd);
          check(ops_seen == e.ops, e.tag, 32'(ops_seen), 32'(e.ops));
        end
        ops_seen = 0;
      end
      prev_rsp = m_rsp;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R8 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    checks = 0; errors = 0; ops_seen = 0; ops_total = 0; wait_c = 0;
    prev_rsp = 1'b0; done = 1'b0; lat_we = 1'b0; lat_addr = '0; lat_size = '0; lat_wdata = '0;
    p_ack = 1'b0; p_rdata = '0;
    m_req = 1'b0; m_we = 1'b0; m_size = '0; m_addr = '0; m_wdata = '0;
    for (int i = 0; i < 512; i++) begin
      pmem[i] = 8'((i * 37 + 5) & 255);
      gold[i] = pmem[i];
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(m_gnt && !p_req && !m_rsp, "R10", {29'd0, m_gnt, p_req, m_rsp}, 32'h4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(m_gnt && !p_req && !m_rsp, "R10", {29'd0, m_gnt, p_req, m_rsp}, 32'h4);

    // matching widths
    issue(0, 0, 'h001, 0, "R4");
    issue(0, 1, 'h012, 0, "R4");
    issue(0, 2, 'h024, 0, "R4");
    issue(1, 1, 'h016, 32'h0000_BEEF, "R4");
    issue(0, 1, 'h016, 0, "R4");
    // narrow reads
    issue(0, 0, 'h012, 0, "R5");
    issue(0, 0, 'h013, 0, "R5");
    issue(0, 0, 'h025, 0, "R5");
    issue(0, 1, 'h026, 0, "R5");
    issue(0, 1, 'h020, 0, "R5");
    // narrow writes
    issue(1, 0, 'h027, 32'h0000_00AB, "R6");
    issue(0, 2, 'h024, 0, "R6");
    issue(1, 1, 'h020, 32'h0000_1234, "R6");
    issue(0, 2, 'h020, 0, "R6");
    issue(1, 0, 'h01C, 32'h0000_005A, "R6");
    issue(0, 1, 'h01C, 0, "R6");
    // wide accesses
    issue(0, 1, 'h002, 0, "R7");
    issue(0, 2, 'h004, 0, "R7");
    issue(0, 2, 'h014, 0, "R7");
    issue(1, 2, 'h008, 32'hCAFE_F00D, "R7");
    issue(0, 0, 'h008, 0, "R7");
    issue(0, 0, 'h00B, 0, "R7");
    issue(0, 2, 'h008, 0, "R7");
    issue(1, 2, 'h018, 32'h0102_0304, "R7");
    issue(0, 1, 'h01A, 0, "R7");
    issue(1, 1, 'h00E, 32'h0000_7788, "R7");
    issue(0, 0, 'h00E, 0, "R7");
    // reserved slots
    issue(0, 2, 'h030, 0, "R3");
    issue(0, 0, 'h03D, 0, "R3");
    issue(1, 2, 'h034, 32'hFFFF_FFFF, "R3");
    issue(0, 2, 'h034, 0, "R3");
    // invalid and aliased offsets
    issue(0, 2, 'h200, 0, "R1");
    issue(1, 2, 'h200, 32'h1111_2222, "R1");
    issue(0, 2, 'h000, 0, "R1");
    issue(0, 2, 'h3FC, 0, "R1");
    issue(0, 2, 'h404, 0, "R1");
    issue(1, 2, 'h428, 32'h5566_7788, "R1");
    issue(0, 2, 'h028, 0, "R1");
    // sweep of all sizes over the window
    for (int a = 0; a < 'h200; a += 4) begin
      issue(1, a % 3, a, 32'(a * 32'h0101_0101 + 7), "R9");
      issue(0, 2, a, 0, "R9");
      issue(0, 0, a + 3, 0, "R9");
    end

    while (exp_q.size() != 0 || !m_gnt) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule